// File: doc/BRIEF.md
# Device control register with timed reset sequencing

This block is a 32-bit control register for a network controller. Software uses it to start two kinds of reset and to quiesce bus mastering. A link reset covers the MAC, PCS and auto-negotiation logic as well as the core. A device reset covers the core only and leaves the link-side logic running. Each reset bit reads as 1 for a parameterised number of clock cycles, about 1 ms in silicon, and then clears itself. Configuration-space state lies outside both reset domains, so the device stays reachable while a reset runs.

The master-disable bit blocks every new bus-master request, including management traffic. The block then watches the count of outstanding master requests. Once master disable is set and that count is zero, it raises a status flag, which tells software that draining is complete. While either reset runs, all writes to the register are dropped. Reads always return the live bit values.

Top module: `dev_ctrl_rst_seq`

## Requirements
- R1: After rst_ni is released, the register reads 0x00000008 (link reset set, all else 0), link_rst_o and core_rst_o are 1, and blk_mst_o and mst_en_sts_o are 0.
- R2: Every bit other than 2, 3 and 26 reads as 0, whatever value was written.
- R3: When no reset is running, a write loads bit 2 (master disable), which reads back and drives blk_mst_o from the next cycle.
- R4: mst_en_sts_o is 1 in the cycle after one in which master disable was 1 and pend_cnt_i was 0, and is 0 otherwise.
- R5: A write with bit 3 set, made while idle, sets bit 3, link_rst_o and core_rst_o from the next cycle for exactly RST_CYCLES cycles, and then clears all three.
- R6: A write with bit 26 set and bit 3 clear, made while idle, sets bit 26 and core_rst_o for exactly RST_CYCLES cycles, and link_rst_o stays 0.
- R7: A write with both bit 3 and bit 26 set starts a link reset only, and bit 26 stays 0.
- R8: A write made while core_rst_o is 1 has no effect on any bit.
- R9: A write that starts either reset clears master disable, whatever bit 2 holds.
- R10: The power-on link reset ends by itself RST_CYCLES cycles after rst_ni is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Live register value |
| pend_cnt_i | input | PEND_W | Outstanding bus-master request count |
| link_rst_o | output | 1 | Reset for the MAC, PCS and auto-negotiation domain |
| core_rst_o | output | 1 | Reset for the core domain |
| blk_mst_o | output | 1 | Block new bus-master requests |
| mst_en_sts_o | output | 1 | Draining is complete under master disable |

## Verification
The register is driven with several write patterns: link reset alone, device reset alone, both reset bits together, an all-ones pattern with both reset bits clear, and writes that arrive while a reset runs. These patterns separate the precedence rule, the masking of reserved bits and the dropping of writes during a reset. The pending count steps down from a non-zero value to zero while master disable is held, and is also raised with master disable clear. This shows that the status flag depends on both conditions together. A reference model checks every cycle, so an off-by-one error in the reset duration shows up at the first edge where the bit clears.

// File: rtl/dev_ctrl_pkg.sv
package dev_ctrl_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned BIT_MD  = 2;
  localparam int unsigned BIT_LNK = 3;
  localparam int unsigned BIT_DEV = 26;
  localparam logic [REG_W-1:0] LIVE_MASK =
    (32'd1 << BIT_MD) | (32'd1 << BIT_LNK) | (32'd1 << BIT_DEV);

  typedef enum logic [1:0] {
    RST_NONE = 2'd0,
    RST_DEV  = 2'd1,
    RST_LINK = 2'd2
  } rst_kind_e;
endpackage

// File: rtl/rst_hold_timer.sv
module rst_hold_timer #(
  parameter int unsigned HOLD = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;

  // power-on reset starts a hold window, so reset loads the counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= LOAD;
    else if (start_i)                 cnt_q <= LOAD;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && !start_i && (cnt_q == '0);
endmodule

// File: rtl/drain_mon.sv
module drain_mon #(
  parameter int unsigned PEND_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blk_i,
  input  logic [PEND_W-1:0] pend_i,
  output logic              done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= blk_i && (pend_i == '0);
  end
endmodule

// File: rtl/dev_ctrl_rst_seq.sv
module dev_ctrl_rst_seq
  import dev_ctrl_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 200000,
  parameter int unsigned PEND_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic [PEND_W-1:0] pend_cnt_i,
  output logic              link_rst_o,
  output logic              core_rst_o,
  output logic              blk_mst_o,
  output logic              mst_en_sts_o
);
  logic      md_q, lnk_q, dev_q;
  logic      busy, wr_ok, done;
  rst_kind_e req;

  assign busy  = lnk_q || dev_q;
  assign wr_ok = wr_en_i && !busy;

  // link scope covers device scope, so it wins
  always_comb begin
    req = RST_NONE;
    if (wr_ok) begin
      if (wr_data_i[BIT_LNK])      req = RST_LINK;
      else if (wr_data_i[BIT_DEV]) req = RST_DEV;
    end
  end

  rst_hold_timer #(.HOLD(RST_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (req != RST_NONE),
    .run_i   (busy),
    .done_o  (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      md_q  <= 1'b0;
      lnk_q <= 1'b1;
      dev_q <= 1'b0;
    end else begin
      if (done) begin
        lnk_q <= 1'b0;
        dev_q <= 1'b0;
      end
      unique case (req)
        RST_LINK: begin lnk_q <= 1'b1; md_q <= 1'b0; end
        RST_DEV:  begin dev_q <= 1'b1; md_q <= 1'b0; end
        default:  if (wr_ok) md_q <= wr_data_i[BIT_MD];
      endcase
    end
  end

  drain_mon #(.PEND_W(PEND_W)) u_drain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .blk_i  (md_q),
    .pend_i (pend_cnt_i),
    .done_o (mst_en_sts_o)
  );

  always_comb begin
    rd_data_o          = '0;
    rd_data_o[BIT_MD]  = md_q;
    rd_data_o[BIT_LNK] = lnk_q;
    rd_data_o[BIT_DEV] = dev_q;
  end

  assign link_rst_o = lnk_q;
  assign core_rst_o = lnk_q || dev_q;
  assign blk_mst_o  = md_q;
endmodule

// File: rtl/dev_ctrl_rst_seq_chk.sv
module dev_ctrl_rst_seq_chk
  import dev_ctrl_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             link_rst_o,
  input logic             core_rst_o,
  input logic             blk_mst_o,
  input logic             mst_en_sts_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~LIVE_MASK) == '0);                                      // R2
  AST_STS_NEEDS_BLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_en_sts_o |-> $past(blk_mst_o));                                   // R4
  AST_LINK_IN_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_rst_o |-> core_rst_o);                                           // R5
  AST_LINK_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_rst_o) |-> $past(wr_en_i) && $past(wr_data_i[BIT_LNK]));   // R5
  AST_BOTH_NO_DEV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_rst_o |-> !rd_data_o[BIT_DEV]);                                  // R7
  AST_BUSY_HOLDS_MD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |=> $stable(blk_mst_o));                                   // R8
  AST_RST_CLEARS_MD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o) |-> !blk_mst_o);                                    // R9
endmodule

bind dev_ctrl_rst_seq dev_ctrl_rst_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .rd_data_o    (rd_data_o),
  .link_rst_o   (link_rst_o),
  .core_rst_o   (core_rst_o),
  .blk_mst_o    (blk_mst_o),
  .mst_en_sts_o (mst_en_sts_o)
);

// File: tb/dev_ctrl_rst_seq_tb.sv
module dev_ctrl_rst_seq_tb;
  localparam int N  = 8;
  localparam int PW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [31:0]   wr_data_i = '0;
  logic [31:0]   rd_data_o;
  logic [PW-1:0] pend_cnt_i = '0;
  logic          link_rst_o, core_rst_o, blk_mst_o, mst_en_sts_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #2.5 clk_i = ~clk_i;

  dev_ctrl_rst_seq #(.RST_CYCLES(N), .PEND_W(PW)) u_dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_data_o, .pend_cnt_i,
    .link_rst_o, .core_rst_o, .blk_mst_o, .mst_en_sts_o
  );

  // behavioural reference
  int m_lnk, m_dev, m_md, m_sts, m_left;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lnk = 1; m_dev = 0; m_md = 0; m_sts = 0; m_left = N;
    end else begin
      m_sts = (m_md != 0 && pend_cnt_i == 0) ? 1 : 0;
      if (m_lnk != 0 || m_dev != 0) begin
        if (m_left == 1) begin m_lnk = 0; m_dev = 0; end
        else m_left = m_left - 1;
      end else if (wr_en_i) begin
        if (wr_data_i[3]) begin m_lnk = 1; m_md = 0; m_left = N; end        // R5 R7 R9
        else if (wr_data_i[26]) begin m_dev = 1; m_md = 0; m_left = N; end // R6 R9
        else m_md = wr_data_i[2] ? 1 : 0;                                   // R3 R2
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cyc=%0d act=%h exp=%h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    cyc++;
    chk("R2/R3/R5/R6/R8 rd_data", rd_data_o,
        {5'b0, m_dev[0], 22'b0, m_lnk[0], m_md[0], 2'b0});
    chk("R5/R10 link_rst", {31'b0, link_rst_o}, {31'b0, m_lnk[0]});
    chk("R6 core_rst", {31'b0, core_rst_o}, {31'b0, m_lnk[0] | m_dev[0]});
    chk("R3 blk_mst", {31'b0, blk_mst_o}, {31'b0, m_md[0]});
    chk("R4 mst_en_sts", {31'b0, mst_en_sts_o}, {31'b0, m_sts[0]});
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk_i); #1; wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); #1; wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk_i);
  endtask

  initial begin
    #12 rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk("R1 reset value", rd_data_o, 32'h0000_0008);
    chk("R1 reset outputs", {28'b0, link_rst_o, core_rst_o, blk_mst_o, mst_en_sts_o}, 32'hC);
    idle(N + 2);
    chk("R10 power-on reset ended", {30'b0, link_rst_o, core_rst_o}, 32'h0);
    pend_cnt_i = 8'd3;
    wr(32'hFBFF_FFF7);                          // R2 R3 reserved + md
    chk("R2 reserved masked", rd_data_o, 32'h0000_0004);
    idle(2); pend_cnt_i = 8'd1; idle(2); pend_cnt_i = 8'd0; idle(3);
    chk("R4 drained", {31'b0, mst_en_sts_o}, 32'h1);
    wr(32'h0000_0008);                          // R5 R9
    chk("R9 md cleared by reset", {31'b0, blk_mst_o}, 32'h0);
    wr(32'h0400_0004);                          // R8 ignored
    idle(N + 2);
    chk("R8 write dropped", rd_data_o, 32'h0);
    wr(32'h0400_0000);                          // R6
    chk("R6 device only", {30'b0, link_rst_o, core_rst_o}, 32'h1);
    idle(N + 2);
    wr(32'h0400_0008);                          // R7
    chk("R7 link wins", rd_data_o, 32'h0000_0008);
    idle(N + 2);
    pend_cnt_i = 8'd0; idle(3);
    chk("R4 no md no status", {31'b0, mst_en_sts_o}, 32'h0);
    wr(32'h0000_0004); idle(3);
    wr(32'h0400_0004);                          // R9 device path
    chk("R9 md cleared by dev reset", {31'b0, blk_mst_o}, 32'h0);
    idle(N + 3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #50000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule